// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is a parameterised shift/storage register (eight bits by default). Its parallel input and its parallel output share one set of bidirectional pins. The shared bus is split into three ports: an input vector sampled on load, an output vector carrying the register contents, and a drive-enable that says when the outputs may be put on the bus. A two-bit select chooses one of four operations: hold, shift toward the high end, shift toward the low end, or parallel load. A synchronous active-low clear takes priority over the select. Every state change happens on the rising clock edge.

Two serial inputs feed the register, one for each shift direction. The lowest and highest bits are also driven on their own outputs at all times. Several instances can therefore be chained into a longer word: the high-end output of one stage feeds the up-shift input of the next stage, and the low-end output of the next stage feeds the down-shift input of the one before.

The drive-enable is combinational. It is low whenever either active-low output enable is high, and also whenever load is selected, so that outside data can reach the pins. Turning the drivers off never stops the register from operating.

Top module: `shreg_bus`

## Requirements
- R1: When `rst_n` is low at a rising edge, all register bits become 0, whatever the value of `sel`.
- R2: With `rst_n` high, `sel` = 2'b11 loads `bus_in[n]` into bit n at the rising edge.
- R3: `sel` = 2'b01 shifts up: `ser_up_in` enters bit 0, bit i-1 moves to bit i, and the top bit is discarded.
- R4: `sel` = 2'b10 shifts down: `ser_dn_in` enters the top bit, bit i+1 moves to bit i, and bit 0 is discarded.
- R5: `sel` = 2'b00 leaves the contents unchanged.
- R6: `bus_drive` is 0 whenever `oe_a_n` or `oe_b_n` is 1.
- R7: `bus_drive` is 0 whenever `sel` = 2'b11. With both enables low and any other select, it is 1. It follows its inputs in the same cycle, with no clock edge needed.
- R8: Clear, hold, shift and load all act on the register while `bus_drive` is 0. The result shows on `bus_out` once the drivers are enabled again.
- R9: `end_lo` always equals bit 0 and `end_hi` always equals the top bit, whatever the enables or the select.
- R10: Two instances chained through their end outputs and serial inputs behave as one 16-bit register when shifting in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous clear, active low |
| sel | input | 2 | Operation select: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_up_in | input | 1 | Serial bit entering bit 0 on an up-shift |
| ser_dn_in | input | 1 | Serial bit entering the top bit on a down-shift |
| oe_a_n | input | 1 | Output enable A, active low |
| oe_b_n | input | 1 | Output enable B, active low |
| bus_in | input | WIDTH | Value present on the shared pins |
| bus_out | output | WIDTH | Register contents offered to the shared pins |
| bus_drive | output | 1 | High when the shared pins are driven |
| end_lo | output | 1 | Continuous copy of bit 0 |
| end_hi | output | 1 | Continuous copy of the top bit |

## Verification
Loads use the patterns A5 and 3C. Their alternating and grouped ones expose a swapped or misplaced bit lane that an all-ones value would hide. Shifts alternate serial ones and zeros in both directions, starting from asymmetric contents. This separates a correct shift from a rotate, from a shift in the wrong direction, and from a shift that takes its serial bit from the wrong input. Clear is applied while load or shift is selected, to show that it overrides them. A run with the drivers disabled, followed by re-enabling them, shows that the register kept working. The chained pair is compared against a 16-bit model over a full 16-step shift in each direction, which checks that bits pass across the stage boundary.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [2:0] {
    OP_CLEAR = 3'd0,
    OP_HOLD  = 3'd1,
    OP_UP    = 3'd2,
    OP_DOWN  = 3'd3,
    OP_LOAD  = 3'd4
  } shreg_op_e;

  localparam logic [1:0] SEL_HOLD = 2'b00;
  localparam logic [1:0] SEL_UP   = 2'b01;
  localparam logic [1:0] SEL_DOWN = 2'b10;
  localparam logic [1:0] SEL_LOAD = 2'b11;
endpackage

// File: rtl/shreg_op_dec.sv
module shreg_op_dec
  import shreg_pkg::*;
(
  input  logic       rst_n,
  input  logic [1:0] sel,
  output shreg_op_e  op
);
  always_comb begin
    if (!rst_n) begin
      op = OP_CLEAR;
    end else begin
      unique case (sel)
        SEL_UP:   op = OP_UP;
        SEL_DOWN: op = OP_DOWN;
        SEL_LOAD: op = OP_LOAD;
        default:  op = OP_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/shreg_cell.sv
module shreg_cell
  import shreg_pkg::*;
(
  input  logic      clk,
  input  shreg_op_e op,
  input  logic      from_below,
  input  logic      from_above,
  input  logic      pin,
  output logic      q
);
  logic d;

  always_comb begin
    unique case (op)
      OP_CLEAR: d = 1'b0;
      OP_UP:    d = from_below;
      OP_DOWN:  d = from_above;
      OP_LOAD:  d = pin;
      default:  d = q;
    endcase
  end

  always_ff @(posedge clk) begin
    q <= d;
  end
endmodule

// File: rtl/shreg_drive_ctl.sv
module shreg_drive_ctl
  import shreg_pkg::*;
(
  input  logic       oe_a_n,
  input  logic       oe_b_n,
  input  logic [1:0] sel,
  output logic       drive
);
  logic enables_on;
  logic load_sel;

  always_comb begin
    enables_on = ~oe_a_n & ~oe_b_n;
    load_sel   = (sel == SEL_LOAD);
    drive      = enables_on & ~load_sel;
  end
endmodule

// File: rtl/shreg_bus.sv
module shreg_bus
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic             ser_up_in,
  input  logic             ser_dn_in,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_drive,
  output logic             end_lo,
  output logic             end_hi
);
  localparam int TOP = WIDTH - 1;

  shreg_op_e        op;
  logic [WIDTH-1:0] q;

  shreg_op_dec u_dec (
    .rst_n (rst_n),
    .sel   (sel),
    .op    (op)
  );

  // below[i] is the bit that enters lane i on an up-shift;
  // above[i] is the bit that enters lane i on a down-shift.
  logic [WIDTH-1:0] below;
  logic [WIDTH-1:0] above;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    if (i == 0) begin : g_first
      assign below[i] = ser_up_in;
    end else begin : g_inner_lo
      assign below[i] = q[i-1];
    end
    if (i == TOP) begin : g_last
      assign above[i] = ser_dn_in;
    end else begin : g_inner_hi
      assign above[i] = q[i+1];
    end

    shreg_cell u_cell (
      .clk        (clk),
      .op         (op),
      .from_below (below[i]),
      .from_above (above[i]),
      .pin        (bus_in[i]),
      .q          (q[i])
    );
  end

  shreg_drive_ctl u_drv (
    .oe_a_n (oe_a_n),
    .oe_b_n (oe_b_n),
    .sel    (sel),
    .drive  (bus_drive)
  );

  assign bus_out = q;
  assign end_lo  = q[0];
  assign end_hi  = q[TOP];
endmodule

// File: rtl/shreg_bus_chk.sv
module shreg_bus_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       sel,
  input logic             ser_up_in,
  input logic             ser_dn_in,
  input logic             oe_a_n,
  input logic             oe_b_n,
  input logic [WIDTH-1:0] bus_in,
  input logic [WIDTH-1:0] bus_out,
  input logic             bus_drive,
  input logic             end_lo,
  input logic             end_hi
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_clear_r1: assert property (@(posedge clk) disable iff (!armed)
    !rst_n |=> bus_out == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (!armed)
    (rst_n && sel == 2'b11) |=> bus_out == $past(bus_in));

  p_up_r3: assert property (@(posedge clk) disable iff (!armed)
    (rst_n && sel == 2'b01) |=>
      bus_out == {$past(bus_out[WIDTH-2:0]), $past(ser_up_in)});

  p_down_r4: assert property (@(posedge clk) disable iff (!armed)
    (rst_n && sel == 2'b10) |=>
      bus_out == {$past(ser_dn_in), $past(bus_out[WIDTH-1:1])});

  p_hold_r5: assert property (@(posedge clk) disable iff (!armed)
    (rst_n && sel == 2'b00) |=> $stable(bus_out));

  p_oe_off_r6: assert property (@(posedge clk) disable iff (!armed)
    (oe_a_n || oe_b_n) |-> !bus_drive);

  p_load_off_r7: assert property (@(posedge clk) disable iff (!armed)
    (sel == 2'b11) |-> !bus_drive);

  p_ends_r9: assert property (@(posedge clk) disable iff (!armed)
    (end_lo == bus_out[0]) && (end_hi == bus_out[WIDTH-1]));

  p_end_in_r9: assert property (@(posedge clk) disable iff (!armed)
    (rst_n && sel == 2'b01) |=> end_lo == $past(ser_up_in));
endmodule

bind shreg_bus shreg_bus_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/shreg_bus_test.sv
module shreg_bus_test;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 12;

  // {rst_n, sel[1:0], ser_up, ser_dn, din[7:0], expected[7:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 2'b11, 1'b0, 1'b0, 8'hA5, 8'h00},  // R1 clear beats load
    {1'b1, 2'b11, 1'b0, 1'b0, 8'hA5, 8'hA5},  // R2
    {1'b1, 2'b00, 1'b0, 1'b0, 8'hFF, 8'hA5},  // R5
    {1'b1, 2'b01, 1'b1, 1'b0, 8'h00, 8'h4B},  // R3
    {1'b1, 2'b01, 1'b0, 1'b1, 8'h00, 8'h96},  // R3
    {1'b1, 2'b10, 1'b0, 1'b1, 8'h00, 8'hCB},  // R4
    {1'b1, 2'b10, 1'b1, 1'b0, 8'h00, 8'h65},  // R4
    {1'b1, 2'b11, 1'b0, 1'b0, 8'h3C, 8'h3C},  // R2
    {1'b0, 2'b01, 1'b1, 1'b1, 8'h00, 8'h00},  // R1 clear beats shift
    {1'b1, 2'b10, 1'b0, 1'b1, 8'h00, 8'h80},  // R4
    {1'b1, 2'b01, 1'b1, 1'b0, 8'h00, 8'h01},  // R3
    {1'b1, 2'b00, 1'b1, 1'b1, 8'hFF, 8'h01}   // R5
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic sr = 1'b0, sl = 1'b0, sl_hi = 1'b0;
  logic oe_a_n = 1'b0, oe_b_n = 1'b0;
  logic [W-1:0] din = '0, din_hi = '0;
  logic chain = 1'b0;

  logic [W-1:0] q_lo, q_hi;
  logic drv_lo, drv_hi, lo_end_lo, lo_end_hi, hi_end_lo, hi_end_hi;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shreg_bus #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .ser_up_in(sr), .ser_dn_in(chain ? hi_end_lo : sl),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_in(din),
    .bus_out(q_lo), .bus_drive(drv_lo), .end_lo(lo_end_lo), .end_hi(lo_end_hi)
  );

  shreg_bus #(.WIDTH(W)) uut_hi (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .ser_up_in(lo_end_hi), .ser_dn_in(sl_hi),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_in(din_hi),
    .bus_out(q_hi), .bus_drive(drv_hi), .end_lo(hi_end_lo), .end_hi(hi_end_hi)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] ref16;
    @(negedge clk);
    step();
    chk("R1 reset state", {8'h00, q_lo}, 16'h0000);
    chk("R7 drive after reset", {15'd0, drv_lo}, 16'd1);

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      {rst_n, sel, sr, sl, din} = VEC[k][20:8];
      #1;
      chk("R7 drive vs select", {15'd0, drv_lo}, {15'd0, (sel != 2'b11)});
      step();
      chk($sformatf("R1-5 vector %0d", k), {8'h00, q_lo}, {8'h00, VEC[k][7:0]});
      chk("R9 end bits", {14'd0, lo_end_hi, lo_end_lo}, {14'd0, VEC[k][7], VEC[k][0]});
    end

    // R6: each enable alone turns the drivers off, in the same cycle
    sel = 2'b00; oe_a_n = 1'b1; #1;
    chk("R6 oe_a_n", {15'd0, drv_lo}, 16'd0);
    oe_a_n = 1'b0; oe_b_n = 1'b1; #1;
    chk("R6 oe_b_n", {15'd0, drv_lo}, 16'd0);
    oe_b_n = 1'b0; #1;
    chk("R7 both low", {15'd0, drv_lo}, 16'd1);

    // R8: work with drivers off, read back after re-enable
    sel = 2'b11; din = 8'h5A; step();
    oe_a_n = 1'b1; sel = 2'b01; sr = 1'b1; step();   // 5A -> B5
    chk("R9 end bits while off", {14'd0, lo_end_hi, lo_end_lo}, 16'h0003);
    sel = 2'b10; sl = 1'b0; step();                   // B5 -> 5A
    sel = 2'b11; din = 8'hC3; step();                 // C3
    sel = 2'b01; sr = 1'b0; step();                   // 86
    sel = 2'b00; oe_a_n = 1'b0; #1;
    chk("R8 work while off", {8'h00, q_lo}, 16'h0086);
    oe_b_n = 1'b1; rst_n = 1'b0; step(); rst_n = 1'b1; oe_b_n = 1'b0;
    chk("R8 clear while off", {8'h00, q_lo}, 16'h0000);

    // R10: chained 16-bit shifts
    chain = 1'b1;
    sel = 2'b11; din = 8'h2D; din_hi = 8'hE1; step();
    ref16 = 16'hE12D;
    chk("R10 chain load", {q_hi, q_lo}, ref16);
    sel = 2'b01;
    for (int k = 0; k < 16; k++) begin
      sr = (k % 3 == 0);
      ref16 = {ref16[14:0], sr};
      step();
      chk("R10 chain up-shift", {q_hi, q_lo}, ref16);
    end
    sel = 2'b10;
    for (int k = 0; k < 16; k++) begin
      sl_hi = (k % 2 == 1);
      ref16 = {sl_hi, ref16[15:1]};
      step();
      chk("R10 chain down-shift", {q_hi, q_lo}, ref16);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule